// File: doc/BRIEF.md
# Sign-Magnitude Add/Subtract Threshold Comparator

This block combines two signed operands that arrive in sign-magnitude form. A run-time select input picks either their sum or their difference. The block then compares that combined value with a programmable threshold and drives an operate output. The comparison can work on the signed value or on its absolute value. It can fire when the signal rises above the threshold or when it falls below it. A hysteresis band keeps the output from chattering near the threshold. A pickup timer and a dropout timer filter the decision. Both timers count pulses of an external tick strobe, so brief glitches do not cause a trip. Such glitches appear when the operand bits do not all switch in the same cycle.

A block input forces the element back to rest. A target output shows the decision in one of three modes: it follows the operate output, it latches until a clear pulse, or it stays off. The combined value is also presented as a saturated sign-magnitude byte for monitoring. That byte never depends on the absolute-value setting.

Top module: `smcmp_top`

## Requirements
- R1: Each operand is a sign-magnitude byte. Bit 7 set means negative, and bits 6..0 are an unsigned magnitude. A negative zero (8'h80) counts as zero.
- R2: `sub_sel` high selects A − B and low selects A + B. The combined value is registered, and `result_sm` shows it on the clock after the operands are sampled.
- R3: `result_sm` holds the sign in bit 7 and the magnitude in bits 6..0. The magnitude saturates at 127. A zero result has bit 7 clear.
- R4: With `cfg_abs` high, the comparison uses the absolute value of the combined result and never of the individual operands. `result_sm` stays signed whatever `cfg_abs` is.
- R5: With `cfg_under` low (over mode), the pickup condition is effective > threshold. The dropout condition is effective < threshold − hysteresis. Between the two levels, an operated element stays operated.
- R6: With `cfg_under` high (under mode), the pickup condition is effective < threshold. The dropout condition is effective > threshold + hysteresis.
- R7: The operate output rises once `cfg_pkp_dly` ticks have been seen while the pickup condition holds without a break. If the condition is lost, the count restarts. With a delay of zero, `operate` rises two clocks after the operand change that causes it.
- R8: An operated element returns to rest once `cfg_drp_dly` ticks have been seen while the dropout condition holds without a break. If the dropout condition is lost while this timer runs, the element stays operated.
- R9: `blk` high clears `operate` and both timers on the next clock. It also clears them during reset.
- R10: `cfg_target` selects the target mode: 2'b01 follows `operate`, 2'b10 latches, and 2'b00 or 2'b11 holds `target` low. In the latched mode `target` stays high after `operate` falls, until `latch_clr` is pulsed while `operate` is low.
- R11: Suppose operand A steps from 15 to 16 but passes through 31 for fewer ticks than the pickup delay, with a threshold between 16 and 31. Then `operate` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 8 | Operand A, sign-magnitude |
| op_b | input | 8 | Operand B, sign-magnitude |
| sub_sel | input | 1 | 1: A − B, 0: A + B |
| cfg_abs | input | 1 | Compare the absolute value of the combined result |
| cfg_under | input | 1 | 0: over mode, 1: under mode |
| cfg_thresh | input | 9 | Threshold, two's complement |
| cfg_hyst | input | 8 | Hysteresis, unsigned |
| cfg_pkp_dly | input | 16 | Pickup delay in ticks |
| cfg_drp_dly | input | 16 | Dropout delay in ticks |
| cfg_target | input | 2 | Target mode |
| tick | input | 1 | Timer strobe, one cycle wide |
| blk | input | 1 | Block: force rest |
| latch_clr | input | 1 | Clears the latched target |
| result_sm | output | 8 | Saturated combined result, sign-magnitude |
| operate | output | 1 | Filtered operate output |
| target | output | 1 | Target indication |

## Verification
Two functions can act in the same cycle. The dropout timer can expire on the very tick that the dropout condition drops back inside the hysteresis band. A block pulse can also land on the cycle the pickup timer would complete. The bench provokes both by moving the operands, `blk` and `tick` on chosen cycles while a timer is running. A behavioural model built from the requirements predicts the outcome cycle by cycle. Each such collision is judged by whether `operate` and `target` match the model on every clock.

// File: rtl/smcmp_pkg.sv
package smcmp_pkg;
   typedef enum logic [1:0] {
      TGT_OFF   = 2'b00,
      TGT_SELF  = 2'b01,
      TGT_LATCH = 2'b10,
      TGT_RSVD  = 2'b11
   } tgt_mode_e;

   typedef enum logic [1:0] {
      ST_REST,
      ST_PKP,
      ST_OPER,
      ST_DRP
   } tmr_state_e;
endpackage

// File: rtl/smcmp_arith.sv
module smcmp_arith #(
   parameter int MAG_W = 7,
   localparam int ACC_W = MAG_W + 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [MAG_W:0]          op_a,
   input  logic [MAG_W:0]          op_b,
   input  logic                    sub_sel,
   output logic signed [ACC_W-1:0] res_q,
   output logic [MAG_W:0]          res_sm
);
   localparam logic [ACC_W-1:0] OUT_MAX = ACC_W'((1 << MAG_W) - 1);

   logic signed [ACC_W-1:0] val_a, val_b, comb;
   logic [ACC_W-1:0]        mag;

   always_comb begin
      val_a = $signed({2'b00, op_a[MAG_W-1:0]});
      val_b = $signed({2'b00, op_b[MAG_W-1:0]});
      if (op_a[MAG_W]) val_a = -val_a;
      if (op_b[MAG_W]) val_b = -val_b;
      comb = sub_sel ? (val_a - val_b) : (val_a + val_b);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) res_q <= '0;
      else        res_q <= comb;
   end

   always_comb begin
      mag = res_q[ACC_W-1] ? ACC_W'(-res_q) : ACC_W'(res_q);
      if (mag > OUT_MAX) mag = OUT_MAX;
      res_sm = {res_q[ACC_W-1], mag[MAG_W-1:0]};
   end
endmodule

// File: rtl/smcmp_level.sv
module smcmp_level #(
   parameter int ACC_W = 9,
   localparam int CMP_W = ACC_W + 2
) (
   input  logic signed [ACC_W-1:0] res,
   input  logic                    cfg_abs,
   input  logic                    cfg_under,
   input  logic [ACC_W-1:0]        cfg_thresh,
   input  logic [ACC_W-2:0]        cfg_hyst,
   output logic                    pu_cond,
   output logic                    do_cond
);
   logic signed [CMP_W-1:0] eff, thr, hys, lo_lvl, hi_lvl;

   always_comb begin
      eff = CMP_W'(res);
      if (cfg_abs && eff < 0) eff = -eff;
      thr    = CMP_W'($signed(cfg_thresh));
      hys    = $signed({3'b000, cfg_hyst});
      lo_lvl = thr - hys;
      hi_lvl = thr + hys;
      if (cfg_under) begin
         pu_cond = eff < thr;
         do_cond = eff > hi_lvl;
      end else begin
         pu_cond = eff > thr;
         do_cond = eff < lo_lvl;
      end
   end
endmodule

// File: rtl/smcmp_timer.sv
module smcmp_timer
   import smcmp_pkg::*;
#(
   parameter int DLY_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             blk,
   input  logic             tick,
   input  logic             pu_cond,
   input  logic             do_cond,
   input  logic [DLY_W-1:0] pkp_dly,
   input  logic [DLY_W-1:0] drp_dly,
   output logic             operate
);
   tmr_state_e       st;
   logic [DLY_W-1:0] cnt;
   logic [DLY_W-1:0] cnt_nx;

   assign cnt_nx  = cnt + 1'b1;
   assign operate = (st == ST_OPER) || (st == ST_DRP);

   always_ff @(posedge clk) begin
      if (!rst_n || blk) begin
         st  <= ST_REST;
         cnt <= '0;
      end else begin
         unique case (st)
            ST_REST: begin
               cnt <= '0;
               if (pu_cond) st <= (pkp_dly == '0) ? ST_OPER : ST_PKP;
            end
            ST_PKP: begin
               if (!pu_cond) begin
                  st  <= ST_REST;
                  cnt <= '0;
               end else if (tick) begin
                  if (cnt_nx >= pkp_dly) begin
                     st  <= ST_OPER;
                     cnt <= '0;
                  end else cnt <= cnt_nx;
               end
            end
            ST_OPER: begin
               cnt <= '0;
               if (do_cond) st <= (drp_dly == '0) ? ST_REST : ST_DRP;
            end
            ST_DRP: begin
               if (!do_cond) begin
                  st  <= ST_OPER;
                  cnt <= '0;
               end else if (tick) begin
                  if (cnt_nx >= drp_dly) begin
                     st  <= ST_REST;
                     cnt <= '0;
                  end else cnt <= cnt_nx;
               end
            end
            default: begin
               st  <= ST_REST;
               cnt <= '0;
            end
         endcase
      end
   end
endmodule

// File: rtl/smcmp_top.sv
module smcmp_top
   import smcmp_pkg::*;
#(
   parameter int MAG_W = 7,
   parameter int DLY_W = 16,
   localparam int ACC_W = MAG_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [MAG_W:0]   op_a,
   input  logic [MAG_W:0]   op_b,
   input  logic             sub_sel,
   input  logic             cfg_abs,
   input  logic             cfg_under,
   input  logic [ACC_W-1:0] cfg_thresh,
   input  logic [ACC_W-2:0] cfg_hyst,
   input  logic [DLY_W-1:0] cfg_pkp_dly,
   input  logic [DLY_W-1:0] cfg_drp_dly,
   input  logic [1:0]       cfg_target,
   input  logic             tick,
   input  logic             blk,
   input  logic             latch_clr,
   output logic [MAG_W:0]   result_sm,
   output logic             operate,
   output logic             target
);
   generate
      if (MAG_W < 2 || MAG_W > 15) begin : g_bad_mag
         $error("smcmp_top: MAG_W out of range");
      end
      if (DLY_W < 1 || DLY_W > 32) begin : g_bad_dly
         $error("smcmp_top: DLY_W out of range");
      end
   endgenerate

   logic signed [ACC_W-1:0] res_q;
   logic                    pu_cond, do_cond;
   logic                    lat_q;
   tgt_mode_e               tmode;

   assign tmode = tgt_mode_e'(cfg_target);

   smcmp_arith #(.MAG_W(MAG_W)) u_arith (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sub_sel(sub_sel),
      .res_q(res_q), .res_sm(result_sm)
   );

   smcmp_level #(.ACC_W(ACC_W)) u_level (
      .res(res_q), .cfg_abs(cfg_abs), .cfg_under(cfg_under),
      .cfg_thresh(cfg_thresh), .cfg_hyst(cfg_hyst),
      .pu_cond(pu_cond), .do_cond(do_cond)
   );

   smcmp_timer #(.DLY_W(DLY_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .blk(blk), .tick(tick),
      .pu_cond(pu_cond), .do_cond(do_cond),
      .pkp_dly(cfg_pkp_dly), .drp_dly(cfg_drp_dly), .operate(operate)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || tmode != TGT_LATCH) lat_q <= 1'b0;
      else if (latch_clr)              lat_q <= 1'b0;
      else                             lat_q <= lat_q | operate;
   end

   always_comb begin
      unique case (tmode)
         TGT_SELF:  target = operate;
         TGT_LATCH: target = operate | lat_q;
         default:   target = 1'b0;
      endcase
   end
endmodule

// File: rtl/smcmp_chk.sv
module smcmp_chk #(
   parameter int MAG_W = 7
) (
   input logic           clk,
   input logic           rst_n,
   input logic [MAG_W:0] op_a,
   input logic [MAG_W:0] op_b,
   input logic           sub_sel,
   input logic           blk,
   input logic           latch_clr,
   input logic [1:0]     cfg_target,
   input logic           pu_cond,
   input logic           do_cond,
   input logic [MAG_W:0] result_sm,
   input logic           operate,
   input logic           target
);
   assert_blk_rest_R9: assert property (@(posedge clk) disable iff (!rst_n)
      blk |=> !operate);

   assert_zero_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (result_sm[MAG_W-1:0] == '0) |-> !result_sm[MAG_W]);

   assert_pos_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_a[MAG_W] && !op_b[MAG_W] && !sub_sel &&
       (|{op_a[MAG_W-1:0], op_b[MAG_W-1:0]}))
      |=> (!result_sm[MAG_W] && (|result_sm[MAG_W-1:0])));

   assert_rise_needs_pickup_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(operate) |-> $past(pu_cond));

   assert_fall_needs_dropout_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(operate) |-> ($past(do_cond) || $past(blk)));

   assert_latch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_target == 2'b10 && target && !latch_clr)
      |=> (target || cfg_target != 2'b10));
endmodule

bind smcmp_top smcmp_chk #(.MAG_W(MAG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sub_sel(sub_sel),
   .blk(blk), .latch_clr(latch_clr), .cfg_target(cfg_target),
   .pu_cond(pu_cond), .do_cond(do_cond), .result_sm(result_sm),
   .operate(operate), .target(target)
);

// File: tb/tb_smcmp_top.sv
`timescale 1ns/1ps
module tb_smcmp_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  op_a = '0, op_b = '0;
   logic        sub_sel = 1'b0, cfg_abs = 1'b0, cfg_under = 1'b0;
   logic [8:0]  cfg_thresh = 9'd200;
   logic [7:0]  cfg_hyst = '0;
   logic [15:0] cfg_pkp_dly = '0, cfg_drp_dly = '0;
   logic [1:0]  cfg_target = 2'b01;
   logic        tick = 1'b0, blk = 1'b0, latch_clr = 1'b0;
   logic [7:0]  result_sm;
   logic        operate, target;

   int checks = 0, fails = 0;
   string cur_req = "R2";

   int m_res = 0, m_st = 0, m_cnt = 0;
   bit m_lat = 1'b0;

   always #4 clk = ~clk;

   smcmp_top dut (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sub_sel(sub_sel),
      .cfg_abs(cfg_abs), .cfg_under(cfg_under), .cfg_thresh(cfg_thresh),
      .cfg_hyst(cfg_hyst), .cfg_pkp_dly(cfg_pkp_dly), .cfg_drp_dly(cfg_drp_dly),
      .cfg_target(cfg_target), .tick(tick), .blk(blk), .latch_clr(latch_clr),
      .result_sm(result_sm), .operate(operate), .target(target)
   );

   function automatic int smval(input logic [7:0] x);
      return x[7] ? -int'(x[6:0]) : int'(x[6:0]);
   endfunction

   function automatic logic [7:0] smenc(input int v);
      int m;
      m = (v < 0) ? -v : v;
      if (m > 127) m = 127;
      return {(v < 0) ? 1'b1 : 1'b0, 7'(m)};
   endfunction

   // Behavioural reference, advanced once per rising edge
   always @(posedge clk) begin
      int eff, thr, hy;
      bit pu, dn, old_op;
      if (!rst_n) begin
         m_res = 0; m_st = 0; m_cnt = 0; m_lat = 1'b0;
      end else begin
         eff = (cfg_abs && m_res < 0) ? -m_res : m_res;
         thr = int'($signed(cfg_thresh));
         hy  = int'(cfg_hyst);
         pu  = cfg_under ? (eff < thr) : (eff > thr);
         dn  = cfg_under ? (eff > thr + hy) : (eff < thr - hy);
         old_op = (m_st == 2 || m_st == 3);
         if (blk) begin m_st = 0; m_cnt = 0; end
         else case (m_st)
            0: begin m_cnt = 0; if (pu) m_st = (cfg_pkp_dly == 0) ? 2 : 1; end
            1: if (!pu) begin m_st = 0; m_cnt = 0; end
               else if (tick) begin
                  m_cnt++;
                  if (m_cnt >= int'(cfg_pkp_dly)) begin m_st = 2; m_cnt = 0; end
               end
            2: begin m_cnt = 0; if (dn) m_st = (cfg_drp_dly == 0) ? 0 : 3; end
            default: if (!dn) begin m_st = 2; m_cnt = 0; end
               else if (tick) begin
                  m_cnt++;
                  if (m_cnt >= int'(cfg_drp_dly)) begin m_st = 0; m_cnt = 0; end
               end
         endcase
         if (cfg_target != 2'b10 || latch_clr) m_lat = 1'b0;
         else m_lat = m_lat | old_op;
         m_res = smval(op_a) + (sub_sel ? -smval(op_b) : smval(op_b));
      end
   end

   // Compare on every falling edge
   always @(negedge clk) begin
      bit e_op, e_tg;
      e_op = (m_st == 2 || m_st == 3);
      e_tg = (cfg_target == 2'b01) ? e_op : (cfg_target == 2'b10) ? (e_op | m_lat) : 1'b0;
      checks += 3;
      if (result_sm !== smenc(m_res)) begin
         fails++;
         $display("FAIL %s result_sm actual %h expected %h", cur_req, result_sm, smenc(m_res));
      end
      if (operate !== e_op) begin
         fails++;
         $display("FAIL %s operate actual %b expected %b", cur_req, operate, e_op);
      end
      if (target !== e_tg) begin
         fails++;
         $display("FAIL %s target actual %b expected %b", cur_req, target, e_tg);
      end
   end

   task automatic run(input int n, input int tick_every);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick = (tick_every > 0) && ((i % tick_every) == tick_every - 1);
      end
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic setab(input logic [7:0] a, input logic [7:0] b, input bit s);
      @(negedge clk);
      op_a = a; op_b = b; sub_sel = s;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      cur_req = "R9";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      run(2, 0);
      // R1 / R2: arithmetic, including negative zero
      cur_req = "R1";
      setab(8'h85, 8'h03, 1'b0); run(2, 0);
      setab(8'h80, 8'h00, 1'b0); run(2, 0);
      cur_req = "R2";
      setab(8'd20, 8'd30, 1'b1); run(2, 0);
      setab(8'h94, 8'h8A, 1'b1); run(2, 0);
      // R3: saturation and zero sign
      cur_req = "R3";
      setab(8'd127, 8'd127, 1'b0); run(2, 0);
      setab(8'hE4, 8'd100, 1'b1); run(2, 0);
      setab(8'd5, 8'd5, 1'b1); run(2, 0);
      // R5: over mode with hysteresis
      cur_req = "R5";
      cfg_thresh = 9'd20; cfg_hyst = 8'd5;
      setab(8'd30, 8'd0, 1'b0); run(3, 0);
      setab(8'd18, 8'd0, 1'b0); run(3, 0);
      setab(8'd14, 8'd0, 1'b0); run(3, 0);
      // R6: under mode
      cur_req = "R6";
      cfg_under = 1'b1; cfg_thresh = 9'h1F6; cfg_hyst = 8'd4;
      setab(8'h94, 8'd0, 1'b0); run(3, 0);
      setab(8'h88, 8'd0, 1'b0); run(3, 0);
      setab(8'h85, 8'd0, 1'b0); run(3, 0);
      // R4: absolute value of the combined result
      cur_req = "R4";
      cfg_under = 1'b0; cfg_abs = 1'b1; cfg_thresh = 9'd30; cfg_hyst = 8'd0;
      setab(8'h90, 8'd24, 1'b1); run(3, 0);
      setab(8'd10, 8'd10, 1'b0); run(3, 0);
      cfg_abs = 1'b0; run(2, 0);
      // R7: pickup delay with an interruption
      cur_req = "R7";
      cfg_thresh = 9'd20; cfg_pkp_dly = 16'd3;
      setab(8'd40, 8'd0, 1'b0); run(4, 2);
      setab(8'd5, 8'd0, 1'b0); run(2, 2);
      setab(8'd40, 8'd0, 1'b0); run(10, 2);
      // R8: dropout delay, condition lost on the expiring tick
      cur_req = "R8";
      cfg_drp_dly = 16'd2; cfg_hyst = 8'd3;
      setab(8'd10, 8'd0, 1'b0); run(3, 2);
      setab(8'd18, 8'd0, 1'b0); run(4, 0);
      setab(8'd10, 8'd0, 1'b0); run(8, 2);
      // R9: block landing on the pickup completion
      cur_req = "R9";
      setab(8'd40, 8'd0, 1'b0); run(5, 2);
      @(negedge clk); blk = 1'b1; tick = 1'b1;
      @(negedge clk); blk = 1'b0; tick = 1'b0;
      run(8, 2);
      @(negedge clk); blk = 1'b1;
      run(2, 0);
      @(negedge clk); blk = 1'b0;
      // R10: target modes
      cur_req = "R10";
      cfg_pkp_dly = 16'd0; cfg_drp_dly = 16'd0; cfg_target = 2'b10;
      run(3, 0);
      setab(8'd0, 8'd0, 1'b0); run(3, 0);
      @(negedge clk); latch_clr = 1'b1;
      @(negedge clk); latch_clr = 1'b0;
      run(2, 0);
      cfg_target = 2'b00;
      setab(8'd40, 8'd0, 1'b0); run(3, 0);
      cfg_target = 2'b11; run(2, 0);
      cfg_target = 2'b01;
      setab(8'd0, 8'd0, 1'b0); run(3, 0);
      // R11: bit-skew glitch 15 -> 31 -> 16 filtered by pickup delay
      cur_req = "R11";
      cfg_pkp_dly = 16'd3;
      setab(8'd15, 8'd0, 1'b0); run(4, 4);
      setab(8'd31, 8'd0, 1'b0); run(2, 4);
      setab(8'd16, 8'd0, 1'b0); run(12, 4);
      finish_run();
   end
endmodule